// File: doc/BRIEF.md
# Clock-Gated Serial Line Receiver

This block turns an asynchronous serial line into parallel words. It watches the line for a falling edge, checks the start bit at its midpoint, and gathers either one byte or two bytes, least significant bit first. An optional parity bit comes next, then the stop bit. Each finished frame is reported as a data word, a parity-error flag, a framing-error flag and a one-cycle valid pulse. Bit timing comes from an external tick that pulses once per sixteenth of a bit period.

Most of the time the line sits high, so the receiver keeps nearly all of its flops frozen. An always-running synchronizer and a single start-detection flop watch the line. The detection flop pulses on a synchronized falling edge, and that pulse raises the clock-enable `gate_en` for everything else. The sampling state machine has the states IDLE, START, DATA, PARITY and STOP. Its transitions are:

- IDLE to START on a detection pulse while receive is enabled.
- START to DATA when the start bit is still low at its midpoint.
- START to IDLE when the start bit is high at its midpoint (rejected).
- DATA to PARITY after the last data bit when parity is included.
- DATA to STOP after the last data bit when no parity is expected.
- PARITY to STOP after the parity bit.
- STOP to IDLE after the stop bit.
- Any busy state to IDLE as soon as receive enable drops.

In IDLE the enable falls again, and the frozen flops hold their values.

Top module: `uart_rx_gated`

## Requirements
- R1: Frames are received only while `rx_en` is 1. With `rx_en` at 0 no `data_valid` is produced and `gate_en` stays 0. Dropping `rx_en` mid-frame abandons the frame, and `gate_en` is 0 in the cycle after `rx_en` is seen low.
- R2: While the state machine is idle and no falling edge has been seen, `gate_en` is 0. The gated state, including `rx_data`, `par_err` and `frm_err`, holds its value.
- R3: A falling edge on `rx`, while `rx_en` is 1 and the receiver is idle, raises `gate_en` by the third falling clock edge after the change, counting from the two-flop synchronizer.
- R4: The start bit is sampled on the 8th oversample tick after START is entered. If the line is high there, the frame is dropped with no `data_valid`, and `gate_en` returns to 0.
- R5: With `cfg_len16` = 0, eight bits are received into `rx_data[7:0]` and `rx_data[15:8]` reads 0. With `cfg_len16` = 1, sixteen bits are received into `rx_data[15:0]`. In both cases the first bit on the line is bit 0. Each bit is sampled on the 16th tick of its period.
- R6: With `cfg_par_off` = 1, no parity bit is expected, the stop bit follows the last data bit, and `par_err` is 0. With `cfg_par_off` = 0, one parity bit follows the data.
- R7: `cfg_par_mode` sets the expected parity bit. 00 is even: the data bits plus parity hold an even count of ones. 01 is odd. 10 expects a constant 0. 11 expects a constant 1.
- R8: `par_err` is 1 for a frame whose parity bit differs from the expected value, and 0 otherwise.
- R9: `data_valid` is a single-cycle pulse at the end of each completed frame. `rx_data`, `par_err` and `frm_err` take that frame's values in the same cycle and hold them until the next completed frame.
- R10: A stop bit sampled as 0 sets `frm_err` to 1, and the data word is still delivered with `data_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receive enable |
| cfg_par_off | input | 1 | 1: no parity bit; 0: parity bit present |
| cfg_par_mode | input | 2 | 00 even, 01 odd, 10 constant 0, 11 constant 1 |
| cfg_len16 | input | 1 | 0: 8 data bits; 1: 16 data bits |
| rx_data | output | 16 | Last received word |
| data_valid | output | 1 | Pulse on frame completion |
| par_err | output | 1 | Parity mismatch in last frame |
| frm_err | output | 1 | Stop bit was 0 in last frame |
| gate_en | output | 1 | Clock enable for the gated receiver flops |

## Verification
The bench builds the block with its defaults: sixteen ticks per bit and 8-bit bytes, which gives 8- and 16-bit words. The tick pulses every fourth clock, so a bit lasts 64 clocks. Edges land at arbitrary phases against the tick, and this tests midpoint sampling across the whole tolerance window. With these values the bench reaches every parity mode, both word lengths, both parity-present settings, a start glitch, a stop bit held low, a frame sent while disabled and one abandoned midway. It compares every clock against a queue of expected frames and against the expected state of the gate.

// File: rtl/uart_rxg_pkg.sv
package uart_rxg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_t;

    typedef enum logic [1:0] {
        PM_EVEN = 2'b00,
        PM_ODD  = 2'b01,
        PM_ZERO = 2'b10,
        PM_ONE  = 2'b11
    } par_mode_t;

endpackage

// File: rtl/uart_rxg_sync_detect.sv
// Always-clocked front end: synchronizer chain plus the lone detection flop.
module uart_rxg_sync_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx,
    input  logic rx_en,
    output logic rx_sync,
    output logic start_det
);

    logic [SYNC_STAGES-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= rx;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign rx_sync = chain_q[SYNC_STAGES-1];

    // Pulses for one cycle when the synchronized line goes from high to low.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) start_det <= 1'b0;
        else        start_det <= rx_en & chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES-2];
    end

endmodule

// File: rtl/uart_rxg_gate_ctrl.sv
// Clock-enable for the gated receiver flops: wake on a detected edge, stay awake while busy.
module uart_rxg_gate_ctrl (
    input  logic start_det,
    input  logic busy,
    output logic gate_en
);

    always_comb begin
        gate_en = start_det | busy;
    end

endmodule

// File: rtl/uart_rxg_parity_chk.sv
module uart_rxg_parity_chk
    import uart_rxg_pkg::*;
(
    input  par_mode_t mode,
    input  logic      data_xor,
    input  logic      rx_bit,
    output logic      mismatch
);

    logic want;

    always_comb begin
        unique case (mode)
            PM_EVEN: want = data_xor;
            PM_ODD:  want = ~data_xor;
            PM_ZERO: want = 1'b0;
            PM_ONE:  want = 1'b1;
            default: want = 1'b0;
        endcase
        mismatch = rx_bit ^ want;
    end

endmodule

// File: rtl/uart_rxg_fsm.sv
module uart_rxg_fsm
    import uart_rxg_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int BYTE_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clk_en,
    input  logic                  tick16,
    input  logic                  rx_sync,
    input  logic                  start_det,
    input  logic                  rx_en,
    input  logic                  cfg_par_off,
    input  logic [1:0]            cfg_par_mode,
    input  logic                  cfg_len16,
    output logic [2*BYTE_W-1:0]   rx_data,
    output logic                  data_valid,
    output logic                  par_err,
    output logic                  frm_err,
    output logic                  busy
);

    localparam int DMAX = 2 * BYTE_W;
    localparam int OS_W = $clog2(OVERSAMPLE);
    localparam int BC_W = $clog2(DMAX);
    localparam logic [OS_W-1:0] OS_MID  = OS_W'(OVERSAMPLE / 2 - 1);
    localparam logic [OS_W-1:0] OS_LAST = OS_W'(OVERSAMPLE - 1);
    localparam logic [BC_W-1:0] BC_LAST8  = BC_W'(BYTE_W - 1);
    localparam logic [BC_W-1:0] BC_LAST16 = BC_W'(DMAX - 1);

    rx_state_t         state_q, state_d;
    logic [OS_W-1:0]   os_q;
    logic [BC_W-1:0]   bit_q;
    logic [DMAX-1:0]   shift_q;
    logic [DMAX-1:0]   data_q;
    logic              xor_q;
    logic              perr_pend_q;
    logic              perr_q, ferr_q, valid_q;
    logic              cfg_len16_q, cfg_paroff_q;
    par_mode_t         cfg_mode_q;

    logic              sample;
    logic [BC_W-1:0]   bit_last;
    logic              par_bad;

    uart_rxg_parity_chk u_par (
        .mode     (cfg_mode_q),
        .data_xor (xor_q),
        .rx_bit   (rx_sync),
        .mismatch (par_bad)
    );

    always_comb begin
        sample   = tick16 && ((state_q == ST_START) ? (os_q == OS_MID) : (os_q == OS_LAST));
        bit_last = cfg_len16_q ? BC_LAST16 : BC_LAST8;
    end

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_det && rx_en) state_d = ST_START;
            end
            ST_START: begin
                if (!rx_en)      state_d = ST_IDLE;
                else if (sample) state_d = rx_sync ? ST_IDLE : ST_DATA;
            end
            ST_DATA: begin
                if (!rx_en) state_d = ST_IDLE;
                else if (sample && (bit_q == bit_last))
                    state_d = cfg_paroff_q ? ST_STOP : ST_PARITY;
            end
            ST_PARITY: begin
                if (!rx_en)      state_d = ST_IDLE;
                else if (sample) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (!rx_en)      state_d = ST_IDLE;
                else if (sample) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register (gated)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state_q <= ST_IDLE;
        else if (clk_en) state_q <= state_d;
    end

    // Datapath and output registers (gated)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_q         <= '0;
            bit_q        <= '0;
            shift_q      <= '0;
            data_q       <= '0;
            xor_q        <= 1'b0;
            perr_pend_q  <= 1'b0;
            perr_q       <= 1'b0;
            ferr_q       <= 1'b0;
            valid_q      <= 1'b0;
            cfg_len16_q  <= 1'b0;
            cfg_paroff_q <= 1'b1;
            cfg_mode_q   <= PM_EVEN;
        end else if (clk_en) begin
            valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    os_q <= '0;
                    if (start_det && rx_en) begin
                        bit_q        <= '0;
                        shift_q      <= '0;
                        xor_q        <= 1'b0;
                        perr_pend_q  <= 1'b0;
                        cfg_len16_q  <= cfg_len16;
                        cfg_paroff_q <= cfg_par_off;
                        cfg_mode_q   <= par_mode_t'(cfg_par_mode);
                    end
                end
                ST_START, ST_DATA, ST_PARITY, ST_STOP: begin
                    if (tick16) os_q <= sample ? '0 : os_q + 1'b1;
                    if (sample && rx_en) begin
                        if (state_q == ST_DATA) begin
                            shift_q[bit_q] <= rx_sync;
                            xor_q          <= xor_q ^ rx_sync;
                            bit_q          <= bit_q + 1'b1;
                        end
                        if (state_q == ST_PARITY) perr_pend_q <= par_bad;
                        if (state_q == ST_STOP) begin
                            data_q  <= cfg_len16_q ? shift_q
                                                   : {{BYTE_W{1'b0}}, shift_q[BYTE_W-1:0]};
                            perr_q  <= cfg_paroff_q ? 1'b0 : perr_pend_q;
                            ferr_q  <= ~rx_sync;
                            valid_q <= 1'b1;
                        end
                    end
                end
                default: os_q <= '0;
            endcase
        end
    end

    // Output process
    always_comb begin
        rx_data    = data_q;
        data_valid = valid_q;
        par_err    = perr_q;
        frm_err    = ferr_q;
        busy       = (state_q != ST_IDLE) || valid_q;
    end

    // R2
    hold_when_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(state_q) && $stable(data_q) && $stable(os_q) && $stable(shift_q)));

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

    // R6
    no_parity_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && cfg_paroff_q) |-> !perr_q);

    // R4
    start_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && rx_en && state_q == ST_START && sample && rx_sync) |=> !valid_q && !busy);

endmodule

// File: rtl/uart_rx_gated.sv
module uart_rx_gated #(
    parameter int OVERSAMPLE  = 16,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick16,
    input  logic                rx,
    input  logic                rx_en,
    input  logic                cfg_par_off,
    input  logic [1:0]          cfg_par_mode,
    input  logic                cfg_len16,
    output logic [2*BYTE_W-1:0] rx_data,
    output logic                data_valid,
    output logic                par_err,
    output logic                frm_err,
    output logic                gate_en
);

    logic rx_sync;
    logic start_det;
    logic busy;

    uart_rxg_sync_detect #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx        (rx),
        .rx_en     (rx_en),
        .rx_sync   (rx_sync),
        .start_det (start_det)
    );

    uart_rxg_gate_ctrl u_gate (
        .start_det (start_det),
        .busy      (busy),
        .gate_en   (gate_en)
    );

    uart_rxg_fsm #(.OVERSAMPLE(OVERSAMPLE), .BYTE_W(BYTE_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .clk_en       (gate_en),
        .tick16       (tick16),
        .rx_sync      (rx_sync),
        .start_det    (start_det),
        .rx_en        (rx_en),
        .cfg_par_off  (cfg_par_off),
        .cfg_par_mode (cfg_par_mode),
        .cfg_len16    (cfg_len16),
        .rx_data      (rx_data),
        .data_valid   (data_valid),
        .par_err      (par_err),
        .frm_err      (frm_err),
        .busy         (busy)
    );

    // R1
    disabled_sleeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !gate_en);

    // R3
    edge_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rx_sync) && $past(rx_en) && !$past(busy)) |-> gate_en);

endmodule

// File: tb/uart_rx_gated_tb.sv
module uart_rx_gated_tb;

    localparam int BITCLK = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick16 = 1'b0;
    logic        rx = 1'b1;
    logic        rx_en = 1'b1;
    logic        cfg_par_off = 1'b1;
    logic [1:0]  cfg_par_mode = 2'b00;
    logic        cfg_len16 = 1'b0;
    logic [15:0] rx_data;
    logic        data_valid, par_err, frm_err, gate_en;

    int compared = 0;
    int mismatched = 0;
    int tdiv = 0;
    int cycles = 0;
    bit quiet = 1'b0;
    bit expect_off = 1'b0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] d;
        logic        pe;
        logic        fe;
        string       tag;
    } exp_t;

    exp_t        expq[$];
    logic [15:0] last_d = 16'h0;
    logic        last_pe = 1'b0;
    logic        last_fe = 1'b0;

    uart_rx_gated u_dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx(rx), .rx_en(rx_en),
        .cfg_par_off(cfg_par_off), .cfg_par_mode(cfg_par_mode), .cfg_len16(cfg_len16),
        .rx_data(rx_data), .data_valid(data_valid), .par_err(par_err),
        .frm_err(frm_err), .gate_en(gate_en)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        tdiv   <= (tdiv == 3) ? 0 : tdiv + 1;
        tick16 <= (tdiv == 3);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // Per-clock comparison against the behavioural model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (data_valid) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R9", "unexpected data_valid", 32'(rx_data), 32'h0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk(rx_data == e.d, e.tag, "rx_data", 32'(rx_data), 32'(e.d));
                    chk(par_err == e.pe, e.tag, "par_err", 32'(par_err), 32'(e.pe));
                    chk(frm_err == e.fe, e.tag, "frm_err", 32'(frm_err), 32'(e.fe));
                    last_d  = e.d;
                    last_pe = e.pe;
                    last_fe = e.fe;
                end
            end
            if (quiet) begin
                chk(gate_en == 1'b0, "R2", "gate_en while idle", 32'(gate_en), 32'h0);
                chk(rx_data == last_d && par_err == last_pe && frm_err == last_fe,
                    "R9", "held result", 32'(rx_data), 32'(last_d));
            end
            if (expect_off)
                chk(gate_en == 1'b0, "R1", "gate_en while disabled", 32'(gate_en), 32'h0);
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            mismatched++;
            compared++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    function automatic logic want_par(input logic [15:0] d, input int n, input logic [1:0] m);
        logic x = 1'b0;
        for (int i = 0; i < n; i++) x ^= d[i];
        case (m)
            2'b00:   return x;
            2'b01:   return ~x;
            2'b10:   return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    // abort_bit < 0: no abort. en = rx_en value during the frame.
    task automatic send(input logic [15:0] d, input bit len16, input bit paroff,
                        input logic [1:0] mode, input bit flip, input bit stopv,
                        input bit en, input int abort_bit, input string tag);
        int n;
        logic [15:0] dm;
        logic pb;
        exp_t e;
        n  = len16 ? 16 : 8;
        dm = len16 ? d : {8'h00, d[7:0]};
        pb = want_par(d, n, mode) ^ flip;
        quiet = 1'b0;
        cfg_len16 = len16;
        cfg_par_off = paroff;
        cfg_par_mode = mode;
        rx_en = en;
        expect_off = !en;
        if (en && abort_bit < 0) begin
            e.d = dm; e.pe = !paroff && flip; e.fe = !stopv; e.tag = tag;
            expq.push_back(e);
        end
        rx = 1'b0;
        repeat (3) @(negedge clk);
        if (en) chk(gate_en == 1'b1, "R3", "gate_en after edge", 32'(gate_en), 32'h1);
        repeat (BITCLK - 3) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            if (i == abort_bit) begin
                rx_en = 1'b0;
                @(negedge clk);
                @(negedge clk);
                chk(gate_en == 1'b0, "R1", "gate_en after abort", 32'(gate_en), 32'h0);
                expect_off = 1'b1;
            end
            rx = d[i];
            repeat (BITCLK) @(negedge clk);
        end
        if (!paroff) begin
            rx = pb;
            repeat (BITCLK) @(negedge clk);
        end
        rx = stopv;
        repeat (BITCLK) @(negedge clk);
        rx = 1'b1;
        repeat (16) @(negedge clk);
        expect_off = 1'b0;
        rx_en = 1'b1;
        @(negedge clk);
        quiet = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(data_valid == 1'b0 && par_err == 1'b0 && frm_err == 1'b0,
            "R9", "reset flags", {29'h0, data_valid, par_err, frm_err}, 32'h0);
        chk(rx_data == 16'h0, "R9", "reset data", 32'(rx_data), 32'h0);
        chk(gate_en == 1'b0, "R2", "reset gate", 32'(gate_en), 32'h0);
        quiet = 1'b1;
        repeat (40) @(negedge clk);

        send(16'h00A5, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 1'b1, -1, "R5");
        send(16'hBEEF, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 1'b1, -1, "R5");
        send(16'h0037, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 1'b1, -1, "R7");
        send(16'h8E13, 1'b1, 1'b0, 2'b01, 1'b0, 1'b1, 1'b1, -1, "R7");
        send(16'h005C, 1'b0, 1'b0, 2'b10, 1'b0, 1'b1, 1'b1, -1, "R7");
        send(16'h00C3, 1'b0, 1'b0, 2'b11, 1'b0, 1'b1, 1'b1, -1, "R7");
        send(16'h0037, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1, -1, "R8");
        send(16'h0081, 1'b0, 1'b0, 2'b11, 1'b1, 1'b1, 1'b1, -1, "R8");
        send(16'h4001, 1'b1, 1'b0, 2'b01, 1'b1, 1'b1, 1'b1, -1, "R8");
        send(16'h0066, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, -1, "R10");
        send(16'h0FF0, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 1'b1, -1, "R6");
        send(16'h005A, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, -1, "R1");
        send(16'h00F0, 1'b0, 1'b0, 2'b01, 1'b0, 1'b1, 1'b1, 3, "R1");

        // R4: start glitch shorter than half a bit
        quiet = 1'b0;
        rx = 1'b0;
        repeat (3) @(negedge clk);
        chk(gate_en == 1'b1, "R3", "gate_en after glitch edge", 32'(gate_en), 32'h1);
        repeat (5) @(negedge clk);
        rx = 1'b1;
        repeat (60) @(negedge clk);
        quiet = 1'b1;
        repeat (40) @(negedge clk);
        chk(expq.size() == 0, "R4", "glitch produced no frame", 32'(expq.size()), 32'h0);

        // back-to-back frames after a good one
        send(16'h0029, 1'b0, 1'b0, 2'b01, 1'b0, 1'b1, 1'b1, -1, "R5");
        send(16'h7FFE, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 1'b1, -1, "R5");

        chk(expq.size() == 0, "R9", "all frames delivered", 32'(expq.size()), 32'h0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule